// File: doc/BRIEF.md
# Cascadable presettable binary counter stage

This block is one stage of a synchronous binary up-counter, four bits wide by default. On each rising clock edge it either clears, takes a parallel preset value, advances by one, or keeps its value. Two separate count enables let identical stages be chained into a counter of any width. The carry-chain enable gates the terminal-count output. The other enable only permits counting, so it can be driven in common to every stage.

The terminal-count output is purely combinational, from the present count and the carry-chain enable. To build a wider counter, wire each stage's `tc_out` to the next stage's `chain_en`, and drive `step_en`, `load_n`, `rst_n` and the clock in common. A build-time parameter picks the reset style. With an asynchronous reset the count clears as soon as `rst_n` falls. With a synchronous reset it clears on the next rising edge. All pins are plain level control and data. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `casc_count_stage`

## Requirements
- R1: With `rst_n` high, `load_n` high and both `step_en` and `chain_en` high, each rising edge adds one to `count_q`, wrapping from all ones (15) to 0.
- R2: With `rst_n` and `load_n` high and either enable low, `count_q` keeps its value across the edge.
- R3: With `rst_n` high and `load_n` low, the rising edge copies `load_val` into `count_q`, whatever the state of both enables.
- R4: `tc_out` is high exactly when `chain_en` is high and `count_q` is all ones, in the same cycle and regardless of `step_en`.
- R5: With `ASYNC_RST` = 1, a low `rst_n` forces `count_q` to 0 at once, without waiting for a clock edge.
- R6: With `ASYNC_RST` = 0, a low `rst_n` leaves `count_q` unchanged until the next rising edge, which sets it to 0.
- R7: A low `rst_n` takes priority over a low `load_n` and over both enables, and the count after reset is 0.
- R8: Stages chained as `tc_out` to the next `chain_en`, sharing `step_en`, form a wider binary counter that increments, holds, presets and wraps as one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, style set by `ASYNC_RST` |
| load_n | input | 1 | Active-low synchronous preset enable |
| load_val | input | W | Preset value |
| step_en | input | 1 | Count enable that does not gate the carry |
| chain_en | input | 1 | Count enable that also gates `tc_out` |
| count_q | output | W | Present count |
| tc_out | output | 1 | Terminal-count carry to the next stage |

## Verification
On every cycle, the embedded properties check the single-edge transitions: a preset lands, an enabled step adds one, a disabled stage holds, a carry high always sits on a full count and is followed by a wrap, and reset leaves a zero count. Only the bench scenarios can show the timing split between the two reset styles within one clock period, where one clears mid-cycle and the other waits for the edge. They also show that a chain of stages behaves as one wide counter across internal carries and a full-width wrap.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [1:0] {
    CCS_CLEAR = 2'd0,
    CCS_LOAD  = 2'd1,
    CCS_STEP  = 2'd2,
    CCS_HOLD  = 2'd3
  } ccs_op_e;
endpackage

// File: rtl/ccs_ctrl.sv
// Priority decode: clear, then preset, then step, else hold.
module ccs_ctrl
  import ccs_pkg::*;
(
  input  logic    rst_n,
  input  logic    load_n,
  input  logic    step_en,
  input  logic    chain_en,
  output ccs_op_e op
);
  always_comb begin
    if (!rst_n)                   op = CCS_CLEAR;
    else if (!load_n)             op = CCS_LOAD;
    else if (step_en && chain_en) op = CCS_STEP;
    else                          op = CCS_HOLD;
  end
endmodule

// File: rtl/ccs_next.sv
module ccs_next
  import ccs_pkg::*;
#(
  parameter int W = 4
) (
  input  ccs_op_e      op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      CCS_CLEAR: nxt = '0;
      CCS_LOAD:  nxt = load_val;
      CCS_STEP:  nxt = cur + ONE;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/ccs_reg.sv
module ccs_reg #(
  parameter int W         = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
      AST_ASYNC_CLEAR: assert property (@(posedge clk)
        !rst_n |-> q == '0);  // R5
    end else begin : g_sync
      always_ff @(posedge clk) begin
        q <= nxt;
      end
      AST_SYNC_CLEAR: assert property (@(posedge clk)
        !rst_n |=> q == '0);  // R6
    end
  endgenerate
endmodule

// File: rtl/ccs_carry.sv
// Look-ahead terminal count: no register on the path to the next stage.
module ccs_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         chain_en,
  output logic         tc
);
  always_comb tc = chain_en & (&cur);
endmodule

// File: rtl/casc_count_stage.sv
module casc_count_stage
  import ccs_pkg::*;
#(
  parameter int W         = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         chain_en,
  output logic [W-1:0] count_q,
  output logic         tc_out
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  ccs_op_e      op;
  logic [W-1:0] nxt;

  ccs_ctrl u_ctrl (
    .rst_n(rst_n), .load_n(load_n), .step_en(step_en),
    .chain_en(chain_en), .op(op)
  );

  ccs_next #(.W(W)) u_next (
    .op(op), .cur(count_q), .load_val(load_val), .nxt(nxt)
  );

  ccs_reg #(.W(W), .ASYNC_RST(ASYNC_RST)) u_reg (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .q(count_q)
  );

  ccs_carry #(.W(W)) u_carry (
    .cur(count_q), .chain_en(chain_en), .tc(tc_out)
  );

  AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && step_en && chain_en |=> count_q == $past(count_q) + ONE);  // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && !(step_en && chain_en) |=> $stable(count_q));  // R2
  AST_PRESET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count_q == $past(load_val));  // R3
  AST_TC_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> count_q == '1);  // R4
  AST_TC_THEN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out && step_en && load_n |=> count_q == '0);  // R4
endmodule

// File: tb/tb_casc_count_stage.sv
`timescale 1ns/1ps
module tb_casc_count_stage;
  localparam int NS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_n = 1'b1;
  logic [11:0] d12 = '0;
  logic        step_en = 1'b0;
  logic        chain_en0 = 1'b0;
  int          n_vec = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  logic [3:0] dq;
  logic       dtc;

  casc_count_stage #(.W(4), .ASYNC_RST(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(d12[3:0]),
    .step_en(step_en), .chain_en(chain_en0), .count_q(dq), .tc_out(dtc)
  );

  // m = 0: asynchronous reset chain, m = 1: synchronous reset chain
  logic [3:0] cq [2][NS];
  logic       ctc[2][NS];
  logic       cce[2][NS];

  for (genvar m = 0; m < 2; m++) begin : g_mode
    for (genvar i = 0; i < NS; i++) begin : g_st
      if (i == 0) begin : g_first
        assign cce[m][i] = chain_en0;
      end else begin : g_rest
        assign cce[m][i] = ctc[m][i-1];
      end
      casc_count_stage #(.W(4), .ASYNC_RST(m == 0)) u_st (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(d12[4*i +: 4]),
        .step_en(step_en), .chain_en(cce[m][i]),
        .count_q(cq[m][i]), .tc_out(ctc[m][i])
      );
    end
  end

  function automatic logic [11:0] wide(input int m);
    return {cq[m][2], cq[m][1], cq[m][0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic r, input logic ld, input logic [11:0] d,
                       input logic se, input logic ce);
    @(negedge clk);
    rst_n = r; load_n = ld; d12 = d; step_en = se; chain_en0 = ce;
  endtask

  task automatic t_reset_state();
    drive(1'b0, 1'b1, 12'h000, 1'b0, 1'b0);
    tick();
    chk("R7 reset dut", int'(dq), 0);
    chk("R7 reset async chain", int'(wide(0)), 0);
    chk("R7 reset sync chain", int'(wide(1)), 0);
    chk("R4 tc low after reset", int'(dtc), 0);
  endtask

  task automatic t_count_wrap();
    drive(1'b1, 1'b0, 12'h7FD, 1'b1, 1'b1);
    tick();
    chk("R3 preset dut", int'(dq), 'hD);
    drive(1'b1, 1'b1, 12'h7FD, 1'b1, 1'b1);
    tick();
    chk("R1 step to E", int'(dq), 'hE);
    chk("R4 tc low at E", int'(dtc), 0);
    tick();
    chk("R1 step to F", int'(dq), 'hF);
    chk("R4 tc high at F", int'(dtc), 1);
    tick();
    chk("R1 wrap to 0", int'(dq), 0);
    chk("R8 async chain carry 800", int'(wide(0)), 'h800);
    chk("R8 sync chain carry 800", int'(wide(1)), 'h800);
  endtask

  task automatic t_hold();
    drive(1'b1, 1'b0, 12'h00F, 1'b1, 1'b1);
    tick();
    drive(1'b1, 1'b1, 12'h000, 1'b0, 1'b1);
    chk("R4 tc ignores step_en", int'(dtc), 1);
    tick();
    tick();
    chk("R2 hold step_en low", int'(dq), 'hF);
    drive(1'b1, 1'b1, 12'h000, 1'b1, 1'b0);
    #2;
    chk("R4 tc gated by chain_en", int'(dtc), 0);
    tick();
    chk("R2 hold chain_en low", int'(dq), 'hF);
    chk("R8 chain hold", int'(wide(0)), 'h00F);
  endtask

  task automatic t_load_priority();
    drive(1'b1, 1'b0, 12'h5A3, 1'b1, 1'b1);
    tick();
    chk("R3 preset over counting", int'(dq), 'h3);
    drive(1'b1, 1'b0, 12'h5A6, 1'b0, 1'b0);
    tick();
    chk("R3 preset with enables low", int'(dq), 'h6);
    chk("R8 wide preset", int'(wide(1)), 'h5A6);
  endtask

  task automatic t_reset_priority();
    drive(1'b1, 1'b0, 12'h123, 1'b0, 1'b0);
    tick();
    drive(1'b0, 1'b0, 12'hFFF, 1'b1, 1'b1);
    tick();
    chk("R7 reset over preset dut", int'(dq), 0);
    chk("R7 reset over preset sync", int'(wide(1)), 0);
    chk("R7 reset over preset async", int'(wide(0)), 0);
  endtask

  task automatic t_reset_styles();
    drive(1'b1, 1'b0, 12'hABC, 1'b0, 1'b0);
    tick();
    drive(1'b1, 1'b1, 12'hABC, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R5 async clears mid-cycle", int'(wide(0)), 0);
    chk("R5 async dut clears", int'(dq), 0);
    chk("R6 sync waits for edge", int'(wide(1)), 'hABC);
    tick();
    chk("R6 sync clears at edge", int'(wide(1)), 0);
  endtask

  task automatic t_cascade();
    drive(1'b1, 1'b0, 12'h0FD, 1'b1, 1'b1);
    tick();
    drive(1'b1, 1'b1, 12'h000, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) tick();
    chk("R8 async chain 0FD+5", int'(wide(0)), 'h102);
    chk("R8 sync chain 0FD+5", int'(wide(1)), 'h102);
    drive(1'b1, 1'b0, 12'hFFE, 1'b1, 1'b1);
    tick();
    drive(1'b1, 1'b1, 12'h000, 1'b1, 1'b1);
    tick();
    chk("R4 chain top carry", int'(ctc[1][2]), 1);
    tick();
    tick();
    chk("R8 full-width wrap", int'(wide(1)), 'h001);
    chk("R8 full-width wrap async", int'(wide(0)), 'h001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_count_wrap();
    t_hold();
    t_load_priority();
    t_reset_priority();
    t_reset_styles();
    t_cascade();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule